// File: doc/BRIEF.md
# Variable-Length Token Flit Deframer

This block sits on the receive side of a token network that carries 16-bit flits. Tokens come in several formats and are one, two or three flits long. The top bits of the first flit select the format through a prefix code: a leading 1 marks a structure-memory token. A leading 00 marks the dominant two-operand format. The prefixes 010 and 011 mark the single-operand format and a bucket of less common formats, and inside that bucket a further 2-bit selector picks the format. The deframer gathers the flits of each token and decides how many it needs from the first flit alone. It then delivers one decoded token per output handshake: a kind code, the routing fields and a payload of up to 24 bits.

The dominant two-operand format needs only two bits of decode. For that format the 9-bit matching-store address is presented on a separate port in the cycle after the first flit is latched, before the data flit has arrived. A pipeline can therefore start its store lookup early. Both sides of the block use valid/ready handshaking. A token that is partly or fully received is held while the consumer stalls.

Top module: `flit_deframer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` and `ms_addr_valid` are 0.
- R2: A first flit with bit 15 set is a 2-flit token of kind 0. `out_head` carries the first flit, `out_data` is the second flit zero-extended to 24 bits, and PE, offset, ctx, port and gen read 0.
- R3: A first flit with bits 15:14 = 00 is a 2-flit token of kind 1. PE is bits 13:12, offset is bits 11:7 (zero-extended), ctx is bits 6:3, port is bit 2 and gen is bits 1:0. `out_data` is the second flit zero-extended.
- R4: In the cycle after a kind-1 first flit is accepted, `ms_addr_valid` is 1 and `ms_addr` = {ctx, offset}, 9 bits. `ms_addr_valid` stays 1 until the token is handed out, and it stays 0 while any other kind is held.
- R5: Bits 15:13 = 010 give a 2-flit token of kind 2. PE is bits 12:11, the 7-bit offset is bits 10:4 and ctx is bits 3:0. `out_data` is the second flit zero-extended.
- R6: Bits 15:13 = 011 with selector bits 10:9 = 00 give a 2-flit token of kind 3. PE is bits 12:11, offset is bits 8:4 and ctx is bits 3:0. From the second flit, data is bits 15:8, port is bit 7 and gen is bits 6:5, and bits 4:0 are ignored.
- R7: Selector 01 gives an instruction-memory write of kind 4. The 7-bit address in bits 8:2 appears as the offset, and flags are bits 1:0. When flag bit 0 is clear the token has 2 flits and `out_data` = {8'h0, flit 2}. When it is set the token has 3 flits and `out_data` = {flit 3 bits 15:8, flit 2}.
- R8: Selector 10 gives a 1-flit token of kind 5. PE is bits 12:11, the offset is bits 8:5 and ctx is bits 4:1.
- R9: Selector 11 is consumed as a 1-flit token of kind 7 with `out_err` = 1. PE is bits 12:11 and all other fields are 0. `out_err` is 0 for every other kind.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output holds steady and `in_ready` is 0. No flit is lost or duplicated under any pattern of stalls.
- R11: When the held token is taken in a cycle, a new first flit is accepted in that same cycle. Back-to-back 1-flit tokens therefore stream at one per cycle with `out_ready` held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit valid |
| in_flit | input | 16 | Input flit |
| in_ready | output | 1 | Deframer can take a flit |
| out_valid | output | 1 | Decoded token available |
| out_ready | input | 1 | Consumer takes the token |
| out_kind | output | 3 | Format code (0,1,2,3,4,5,7) |
| out_err | output | 1 | Spare sub-format received |
| out_head | output | 16 | Raw first flit |
| out_pe | output | 2 | Destination PE field |
| out_offset | output | 7 | Offset or instruction address |
| out_ctx | output | 4 | Context field |
| out_port | output | 1 | Operand port |
| out_gen | output | 2 | Generation field |
| out_data | output | 24 | Payload |
| ms_addr_valid | output | 1 | Early matching-store address valid |
| ms_addr | output | 9 | Early matching-store address {ctx, offset} |

## Verification
A wrong flit count breaks framing, and every later token then decodes from the wrong first flit. A count that runs one short or one long therefore shows up at the ports as a kind or field mismatch on the very next token, not only on the token where the error happened. A corrupted held-token register shows up during a consumer stall, as an output that changes without a handshake. A wrong head classification shows up one cycle after the first flit, as a missing or spurious early store address.

// File: rtl/tokfmt_pkg.sv
package tokfmt_pkg;
  localparam int FLIT_W    = 16;
  localparam int DATA_W    = 24;
  localparam int OFF_W     = 7;
  localparam int CTX_W     = 4;
  localparam int MAX_FLITS = 3;
  localparam int CNT_W     = $clog2(MAX_FLITS + 1);
  localparam int MS_ADDR_W = CTX_W + 5;

  typedef enum logic [2:0] {
    K_SM  = 3'd0,
    K_DYW = 3'd1,
    K_MON = 3'd2,
    K_DYN = 3'd3,
    K_IRW = 3'd4,
    K_MIN = 3'd5,
    K_BAD = 3'd7
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic              err;
    logic [1:0]        pe;
    logic [OFF_W-1:0]  offset;
    logic [CTX_W-1:0]  ctx;
    logic              port;
    logic [1:0]        gen;
    logic [DATA_W-1:0] data;
    logic [CNT_W-1:0]  len;
  } tok_t;
endpackage

// File: rtl/fd_classify.sv
// Combinational decode of a (possibly partial) token from its held flits.
module fd_classify
  import tokfmt_pkg::*;
(
  input  logic [FLIT_W-1:0] head,
  input  logic [FLIT_W-1:0] f1,
  input  logic [FLIT_W-1:0] f2,
  output tok_t              tok
);
  logic unused_f2_low;
  assign unused_f2_low = ^f2[7:0];

  always_comb begin
    tok      = '0;
    tok.kind = K_BAD;
    tok.len  = CNT_W'(1);
    if (head[15]) begin
      tok.kind = K_SM;
      tok.len  = CNT_W'(2);
      tok.data = {8'h00, f1};
    end else if (!head[14]) begin
      tok.kind   = K_DYW;
      tok.len    = CNT_W'(2);
      tok.pe     = head[13:12];
      tok.offset = {2'b00, head[11:7]};
      tok.ctx    = head[6:3];
      tok.port   = head[2];
      tok.gen    = head[1:0];
      tok.data   = {8'h00, f1};
    end else if (!head[13]) begin
      tok.kind   = K_MON;
      tok.len    = CNT_W'(2);
      tok.pe     = head[12:11];
      tok.offset = head[10:4];
      tok.ctx    = head[3:0];
      tok.data   = {8'h00, f1};
    end else begin
      tok.pe = head[12:11];
      unique case (head[10:9])
        2'b00: begin
          tok.kind   = K_DYN;
          tok.len    = CNT_W'(2);
          tok.offset = {2'b00, head[8:4]};
          tok.ctx    = head[3:0];
          tok.data   = {16'h0000, f1[15:8]};
          tok.port   = f1[7];
          tok.gen    = f1[6:5];
        end
        2'b01: begin
          tok.kind   = K_IRW;
          tok.offset = head[8:2];
          tok.len    = head[0] ? CNT_W'(3) : CNT_W'(2);
          tok.data   = head[0] ? {f2[15:8], f1} : {8'h00, f1};
        end
        2'b10: begin
          tok.kind   = K_MIN;
          tok.offset = {3'b000, head[8:5]};
          tok.ctx    = head[4:1];
        end
        default: begin
          tok.kind = K_BAD;
          tok.err  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/fd_collect.sv
// Flit slots, fill counter and the two handshakes.
module fd_collect #(
  parameter int W     = 16,
  parameter int SLOTS = 3,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [W-1:0]            in_flit,
  output logic                    in_ready,
  input  logic [CW-1:0]           need,
  input  logic                    out_ready,
  output logic                    full,
  output logic                    busy,
  output logic [SLOTS-1:0][W-1:0] slots
);
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          accept, pop;
  logic [W-1:0]  slot_q [SLOTS];

  assign busy     = (cnt_q != '0);
  assign full     = busy && (cnt_q == need);
  assign pop      = full && out_ready;
  assign in_ready = !full || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    base  = pop ? '0 : cnt_q;
    cnt_d = base;
    if (accept) cnt_d = base + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (accept && (base == CW'(i))) slot_q[i] <= in_flit;
    end
    assign slots[i] = slot_q[i];
  end
endmodule

// File: rtl/flit_deframer.sv
module flit_deframer
  import tokfmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 in_ready,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_kind,
  output logic                 out_err,
  output logic [FLIT_W-1:0]    out_head,
  output logic [1:0]           out_pe,
  output logic [OFF_W-1:0]     out_offset,
  output logic [CTX_W-1:0]     out_ctx,
  output logic                 out_port,
  output logic [1:0]           out_gen,
  output logic [DATA_W-1:0]    out_data,
  output logic                 ms_addr_valid,
  output logic [MS_ADDR_W-1:0] ms_addr
);
  logic [MAX_FLITS-1:0][FLIT_W-1:0] slots;
  logic full, busy;
  tok_t tok;

  fd_collect #(.W(FLIT_W), .SLOTS(MAX_FLITS)) u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_flit   (in_flit),
    .in_ready  (in_ready),
    .need      (tok.len),
    .out_ready (out_ready),
    .full      (full),
    .busy      (busy),
    .slots     (slots)
  );

  fd_classify u_classify (
    .head (slots[0]),
    .f1   (slots[1]),
    .f2   (slots[2]),
    .tok  (tok)
  );

  assign out_valid     = full;
  assign out_kind      = tok.kind;
  assign out_err       = tok.err;
  assign out_head      = slots[0];
  assign out_pe        = tok.pe;
  assign out_offset    = tok.offset;
  assign out_ctx       = tok.ctx;
  assign out_port      = tok.port;
  assign out_gen       = tok.gen;
  assign out_data      = tok.data;
  assign ms_addr_valid = busy && (tok.kind == K_DYW);
  assign ms_addr       = {tok.ctx, tok.offset[4:0]};
endmodule

// File: rtl/flit_deframer_chk.sv
module flit_deframer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [2:0]  out_kind,
  input logic        out_err,
  input logic [15:0] out_head,
  input logic [6:0]  out_offset,
  input logic [3:0]  out_ctx,
  input logic [23:0] out_data,
  input logic        ms_addr_valid,
  input logic [8:0]  ms_addr
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) &&
                                $stable(out_data) && $stable(out_head));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == 3'd1 |-> ms_addr_valid &&
                                      ms_addr == {out_ctx, out_offset[4:0]});

  p_spare_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_head[15:13] == 3'b011 && out_head[10:9] == 2'b11);

  p_sm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head[15] |-> out_kind == 3'd0 && !out_err);

  p_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind flit_deframer flit_deframer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_kind      (out_kind),
  .out_err       (out_err),
  .out_head      (out_head),
  .out_offset    (out_offset),
  .out_ctx       (out_ctx),
  .out_data      (out_data),
  .ms_addr_valid (ms_addr_valid),
  .ms_addr       (ms_addr)
);

// File: tb/flit_deframer_bench.sv
module flit_deframer_bench;
  logic        clk, rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_flit, out_head;
  logic [2:0]  out_kind;
  logic        out_err, out_port;
  logic [1:0]  out_pe, out_gen;
  logic [6:0]  out_offset;
  logic [3:0]  out_ctx;
  logic [23:0] out_data;
  logic        ms_addr_valid;
  logic [8:0]  ms_addr;

  typedef struct packed {
    logic [2:0] kind; logic err; logic [15:0] head; logic [1:0] pe;
    logic [6:0] off; logic [3:0] ctx; logic port; logic [1:0] gen; logic [23:0] data;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int    checks = 0, errors = 0, stalls = 0, cyc = 0, rdy_mode = 0;

  flit_deframer u_flit_deframer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_err(out_err), .out_head(out_head),
    .out_pe(out_pe), .out_offset(out_offset), .out_ctx(out_ctx),
    .out_port(out_port), .out_gen(out_gen), .out_data(out_data),
    .ms_addr_valid(ms_addr_valid), .ms_addr(ms_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // consumer ready pattern
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      cyc++;
      out_ready = (rdy_mode == 0) || (cyc % 3 == 0);
    end
  end

  // monitor: pop expected tokens at handshake, check holding during stalls
  initial begin
    exp_t got, prev, e;
    string r;
    bit stalled = 0;
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        got = {out_kind, out_err, out_head, out_pe, out_offset, out_ctx,
               out_port, out_gen, out_data};
        if (stalled) chk(got == prev, "R10", "held token", 64'(got), 64'(prev));
        stalled = 0;
        if (out_ready) begin
          if (exp_q.size() == 0) chk(0, "R10", "extra token", 64'(got), 64'(0));
          else begin
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(got == e, r, "token", 64'(got), 64'(e));
          end
        end else begin
          chk(!in_ready, "R10", "in_ready during stall", 64'(in_ready), 64'(0));
          stalled = 1;
          prev = got;
        end
      end
    end
  end

  task automatic send(input logic [15:0] f0, f1, f2, input int n, input exp_t e,
                      input string r, input int gap, input bit early,
                      input bit mav, input logic [8:0] maddr);
    logic [15:0] fl [3];
    fl[0] = f0; fl[1] = f1; fl[2] = f2;
    exp_q.push_back(e);
    req_q.push_back(r);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_flit  = fl[i];
      @(negedge clk);
      while (!in_ready) begin stalls++; @(negedge clk); end
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (i == 0 && early) begin
        @(negedge clk);
        chk(ms_addr_valid == mav && (!mav || ms_addr == maddr), "R4", "early address",
            64'({ms_addr_valid, ms_addr}), 64'({mav, maddr}));
        @(posedge clk); #1;
      end
      repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  task automatic t_dyw(input logic [1:0] pe, input logic [4:0] off, input logic [3:0] ctx,
                       input logic port, input logic [1:0] gen, input logic [15:0] d,
                       input int gap, input bit early);
    logic [15:0] h = {2'b00, pe, off, ctx, port, gen};
    send(h, d, 16'h0, 2, {3'd1, 1'b0, h, pe, {2'b00, off}, ctx, port, gen, {8'h00, d}},
         "R3", gap, early, 1'b1, {ctx, off});
  endtask

  task automatic t_sm(input logic [14:0] body, input logic [15:0] d, input int gap);
    logic [15:0] h = {1'b1, body};
    send(h, d, 16'h0, 2, {3'd0, 1'b0, h, 2'b00, 7'h0, 4'h0, 1'b0, 2'b00, {8'h00, d}},
         "R2", gap, 1'b0, 1'b0, 9'h0);
  endtask

  task automatic t_mon(input logic [1:0] pe, input logic [6:0] off, input logic [3:0] ctx,
                       input logic [15:0] d, input int gap, input bit early);
    logic [15:0] h = {3'b010, pe, off, ctx};
    send(h, d, 16'h0, 2, {3'd2, 1'b0, h, pe, off, ctx, 1'b0, 2'b00, {8'h00, d}},
         "R5", gap, early, 1'b0, 9'h0);
  endtask

  task automatic t_dyn(input logic [1:0] pe, input logic [4:0] off, input logic [3:0] ctx,
                       input logic [7:0] d, input logic port, input logic [1:0] gen);
    logic [15:0] h = {3'b011, pe, 2'b00, off, ctx};
    send(h, {d, port, gen, 5'b10101}, 16'h0, 2,
         {3'd3, 1'b0, h, pe, {2'b00, off}, ctx, port, gen, {16'h0, d}},
         "R6", 0, 1'b0, 1'b0, 9'h0);
  endtask

  task automatic t_irw(input logic [1:0] pe, input logic [6:0] a, input logic [1:0] fl,
                       input logic [15:0] lo, input logic [7:0] hi);
    logic [15:0] h = {3'b011, pe, 2'b01, a, fl};
    send(h, lo, {hi, 8'h5A}, fl[0] ? 3 : 2,
         {3'd4, 1'b0, h, pe, a, 4'h0, 1'b0, 2'b00, (fl[0] ? {hi, lo} : {8'h00, lo})},
         "R7", 0, 1'b0, 1'b0, 9'h0);
  endtask

  task automatic t_min(input logic [1:0] pe, input logic [3:0] off, input logic [3:0] ctx,
                       input logic sp);
    logic [15:0] h = {3'b011, pe, 2'b10, off, ctx, sp};
    send(h, 16'h0, 16'h0, 1, {3'd5, 1'b0, h, pe, {3'b000, off}, ctx, 1'b0, 2'b00, 24'h0},
         "R8", 0, 1'b0, 1'b0, 9'h0);
  endtask

  task automatic t_bad(input logic [1:0] pe, input logic [8:0] rest);
    logic [15:0] h = {3'b011, pe, 2'b11, rest};
    send(h, 16'h0, 16'h0, 1, {3'd7, 1'b1, h, pe, 7'h0, 4'h0, 1'b0, 2'b00, 24'h0},
         "R9", 0, 1'b0, 1'b0, 9'h0);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_flit = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !ms_addr_valid, "R1", "reset state",
        64'({in_ready, out_valid, ms_addr_valid}), 64'(3'b100));
    @(posedge clk); #1;

    // always-ready consumer
    t_dyw(2'd2, 5'd19, 4'd11, 1'b1, 2'd3, 16'hBEEF, 1, 1'b1);
    t_sm(15'h5A3C, 16'h1234, 0);
    t_mon(2'd1, 7'd100, 4'd6, 16'hC0DE, 1, 1'b1);
    t_dyn(2'd3, 5'd31, 4'd9, 8'hA7, 1'b0, 2'd2);
    t_irw(2'd0, 7'd77, 2'b01, 16'h9876, 8'hE1);
    t_irw(2'd1, 7'd5, 2'b10, 16'h4321, 8'hFF);
    t_min(2'd2, 4'd13, 4'd14, 1'b1);
    t_bad(2'd1, 9'h1AB);
    t_dyw(2'd0, 5'd0, 4'd15, 1'b0, 2'd1, 16'h0001, 0, 1'b0);
    drain();

    // R11: 1-flit tokens back to back, no input stall expected
    stalls = 0;
    t_min(2'd0, 4'd1, 4'd2, 1'b0);
    t_min(2'd1, 4'd3, 4'd4, 1'b1);
    t_bad(2'd2, 9'h055);
    t_min(2'd3, 4'd15, 4'd0, 1'b0);
    chk(stalls == 0, "R11", "input stalls in stream", 64'(stalls), 64'(0));
    drain();

    // stalling consumer
    rdy_mode = 1;
    t_irw(2'd3, 7'd127, 2'b11, 16'hFACE, 8'h3C);
    t_dyw(2'd1, 5'd7, 4'd3, 1'b1, 2'd0, 16'h7777, 0, 1'b0);
    t_min(2'd1, 4'd6, 4'd5, 1'b0);
    t_sm(15'h0001, 16'hFFFF, 0);
    t_dyn(2'd0, 5'd1, 4'd1, 8'h11, 1'b1, 2'd1);
    t_bad(2'd3, 9'h000);
    t_mon(2'd3, 7'd0, 4'd15, 16'h0F0F, 0, 1'b0);
    drain();
    chk(exp_q.size() == 0, "R10", "all tokens delivered", 64'(exp_q.size()), 64'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule